// File: doc/BRIEF.md
# PDM Microphone Clock and Sample Strobe Generator

This block derives the bit clock for a pulse-density-modulated microphone from a much faster system clock by integer division. One free-running counter produces a square-wave microphone clock together with a one-cycle sample strobe in the system clock domain. Downstream decimation logic uses the strobe to capture one PDM bit per microphone clock period. A static edge-select output tells the microphone on which clock edge it should drive its data.

The division factor is the system clock frequency divided by the PDM bit rate. For example, a 96 MHz system clock and a 2.4 MHz microphone clock give a factor of 40. Typical microphone clocks lie between about 1.5 MHz and 2.4 MHz.

Two phasings are offered. In the falling-drive phasing the microphone clock rises in the strobe cycle. In the rising-drive phasing it falls in the strobe cycle. In both cases the strobe falls half a microphone period after the edge on which the microphone launches its bit, so the data has settled by the time it is captured. An enable input starts and stops generation. While the block is stopped, the clock output is parked low.

Top module: `pdm_clkgen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `mic_clk` and `smp_stb` are 0 and `edge_sel` equals the drive-edge parameter.
- R2: While `en` stays high, `smp_stb` is high for exactly one cycle in every `DIV` cycles.
- R3: With the falling-drive setting (`DRIVE_EDGE` = 0), `mic_clk` is high for the `DIV/2` cycles starting with the strobe cycle, and low for the next `DIV/2` cycles.
- R4: With the rising-drive setting (`DRIVE_EDGE` = 1), `mic_clk` is the inverse of R3 while enabled: it is low for the `DIV/2` cycles starting with the strobe cycle, then high for `DIV/2` cycles.
- R5: One cycle after `en` is sampled low, `smp_stb` and `mic_clk` are both 0, and they stay 0 for as long as `en` stays low, in either setting.
- R6: After an edge where `en` was sampled high following a stop, the next cycle is a strobe cycle. The count restarts from the beginning of a period, whatever its position was when the block stopped.
- R7: `edge_sel` is 1 for the rising-drive setting and 0 for the falling-drive setting. It never changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| en | input | 1 | Run enable for clock and strobe generation |
| mic_clk | output | 1 | Square-wave clock to the microphone, frequency clk/DIV |
| smp_stb | output | 1 | One-cycle capture strobe, once per microphone clock period |
| edge_sel | output | 1 | Drive-edge select to the microphone (1 = rising, 0 = falling) |

## Verification
The bench builds two copies side by side with `DIV` = 8, one with each drive-edge setting, and feeds both the same enable. The small divider puts many complete periods, wraps and half-period boundaries within a short run. Sharing the enable lets each enable pattern exercise both polarities in the same cycles. The enable is dropped at several positions inside a period, and one run lasts a single cycle, so the restart-from-zero and parked-low behaviour are reached at positions other than the wrap.

// File: rtl/pdm_clkgen_pkg.sv
package pdm_clkgen_pkg;

   // Which microphone clock edge the microphone launches data on.
   typedef enum logic {
      DRIVE_FALL = 1'b0,
      DRIVE_RISE = 1'b1
   } drive_edge_e;

endpackage

// File: rtl/pdm_clkgen_counter.sv
// Period counter: wraps at DIV-1 while running, restarts from 0 on a start.
module pdm_clkgen_counter #(
   parameter int unsigned DIV = 40,
   localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   output logic [CW-1:0] cnt_nxt,
   output logic          run_nxt
);

   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   logic [CW-1:0] cnt_q;
   logic          run_q;

   always_comb begin
      run_nxt = en;
      if (!en) begin
         cnt_nxt = '0;
      end else if (!run_q) begin
         cnt_nxt = '0;
      end else if (cnt_q == LAST) begin
         cnt_nxt = '0;
      end else begin
         cnt_nxt = cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else begin
         cnt_q <= cnt_nxt;
         run_q <= run_nxt;
      end
   end

endmodule

// File: rtl/pdm_clkgen_phase.sv
// Turns the next count into registered strobe and clock outputs.
module pdm_clkgen_phase
   import pdm_clkgen_pkg::*;
#(
   parameter int unsigned DIV        = 40,
   parameter drive_edge_e DRIVE_EDGE = DRIVE_FALL,
   localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] cnt_nxt,
   input  logic          run_nxt,
   output logic          stb_o,
   output logic          clk_o
);

   localparam logic [CW-1:0] HALF = CW'(DIV / 2);

   logic first_half;
   logic level_run;

   assign first_half = (cnt_nxt < HALF);

   generate
      if (DRIVE_EDGE == DRIVE_RISE) begin : g_rise
         assign level_run = ~first_half;
      end else begin : g_fall
         assign level_run = first_half;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stb_o <= 1'b0;
         clk_o <= 1'b0;
      end else begin
         stb_o <= run_nxt && (cnt_nxt == '0);
         clk_o <= run_nxt && level_run;
      end
   end

endmodule

// File: rtl/pdm_clkgen.sv
// PDM microphone clock and sample strobe generator.
module pdm_clkgen
   import pdm_clkgen_pkg::*;
#(
   parameter int unsigned DIV        = 40,
   parameter drive_edge_e DRIVE_EDGE = DRIVE_FALL
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic mic_clk,
   output logic smp_stb,
   output logic edge_sel
);

   localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV < 2) begin : g_bad_small
         $error("pdm_clkgen: DIV must be at least 2");
      end
      if ((DIV % 2) != 0) begin : g_bad_odd
         $error("pdm_clkgen: DIV must be even for a 50%% duty clock");
      end
   endgenerate

   logic [CW-1:0] cnt_nxt;
   logic          run_nxt;

   pdm_clkgen_counter #(.DIV(DIV)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .cnt_nxt (cnt_nxt),
      .run_nxt (run_nxt)
   );

   pdm_clkgen_phase #(.DIV(DIV), .DRIVE_EDGE(DRIVE_EDGE)) u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt_nxt (cnt_nxt),
      .run_nxt (run_nxt),
      .stb_o   (smp_stb),
      .clk_o   (mic_clk)
   );

   assign edge_sel = (DRIVE_EDGE == DRIVE_RISE);

endmodule

// File: rtl/pdm_clkgen_chk.sv
module pdm_clkgen_chk
   import pdm_clkgen_pkg::*;
#(
   parameter int unsigned DIV        = 40,
   parameter drive_edge_e DRIVE_EDGE = DRIVE_FALL
) (
   input logic clk,
   input logic rst_n,
   input logic en,
   input logic mic_clk,
   input logic smp_stb,
   input logic edge_sel
);

   localparam int unsigned GW = $clog2(DIV) + 2;
   localparam logic [GW-1:0] GMAX = '1;
   localparam logic RISE = (DRIVE_EDGE == DRIVE_RISE);

   logic [GW-1:0] gap;
   logic          seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap  <= '0;
         seen <= 1'b0;
      end else begin
         if (smp_stb) begin
            gap  <= '0;
            seen <= 1'b1;
         end else if (gap != GMAX) begin
            gap <= gap + 1'b1;
         end
         if (!en) seen <= 1'b0;
      end
   end

   // R2: strobes are one cycle wide and spaced DIV cycles apart
   p_stb_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      smp_stb |=> !smp_stb);
   p_stb_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_stb && seen) |-> (gap == GW'(DIV - 1)));

   // R3 / R4: clock level in the strobe cycle follows the drive-edge setting
   p_stb_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
      smp_stb |-> (mic_clk == !RISE));

   generate
      if (DRIVE_EDGE == DRIVE_RISE) begin : g_rise_chk
         // R4: a running clock falls only in a strobe cycle
         p_fall_at_stb_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(mic_clk) && $past(en)) |-> smp_stb);
      end else begin : g_fall_chk
         // R3: the clock rises only in a strobe cycle
         p_rise_at_stb_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(mic_clk) |-> smp_stb);
      end
   endgenerate

   // R5: parked outputs once stopped
   p_off_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!smp_stb && !mic_clk));

   // R6: a start produces a strobe in the next cycle
   p_start_stb_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en) |=> smp_stb);

   // R7: edge select never moves
   p_edge_sel_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(edge_sel));

endmodule

bind pdm_clkgen pdm_clkgen_chk #(.DIV(DIV), .DRIVE_EDGE(DRIVE_EDGE)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en       (en),
   .mic_clk  (mic_clk),
   .smp_stb  (smp_stb),
   .edge_sel (edge_sel)
);

// File: tb/tb_pdm_clkgen.sv
`timescale 1ns/1ps
module tb_pdm_clkgen;
   import pdm_clkgen_pkg::*;

   localparam int unsigned DIV  = 8;
   localparam int unsigned HALF = DIV / 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en = 1'b0;
   logic mclk_f, stb_f, esel_f;
   logic mclk_r, stb_r, esel_r;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   pdm_clkgen #(.DIV(DIV), .DRIVE_EDGE(DRIVE_FALL)) dut (
      .clk(clk), .rst_n(rst_n), .en(en),
      .mic_clk(mclk_f), .smp_stb(stb_f), .edge_sel(esel_f));

   pdm_clkgen #(.DIV(DIV), .DRIVE_EDGE(DRIVE_RISE)) dut_r (
      .clk(clk), .rst_n(rst_n), .en(en),
      .mic_clk(mclk_r), .smp_stb(stb_r), .edge_sel(esel_r));

   typedef struct {
      bit    stb;
      bit    clkf;
      bit    clkr;
      string tag_stb;
      string tag_f;
      string tag_r;
   } exp_t;

   exp_t q[$];

   // reference model state
   int  m_cnt = 0;
   bit  m_run = 0;

   task automatic check(input string req, input string what,
                        input logic act, input logic expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, expv, $time);
      end
   endtask

   // Driver: applies enable for one cycle and queues what must follow.
   task automatic drive(input bit v);
      exp_t e;
      bit restart;
      @(negedge clk);
      en = v;
      restart = v && !m_run;
      if (v) begin
         m_cnt = (!m_run || m_cnt == DIV - 1) ? 0 : m_cnt + 1;
         m_run = 1;
      end else begin
         m_cnt = 0;
         m_run = 0;
      end
      e.stb  = v && (m_cnt == 0);
      e.clkf = v && (m_cnt < HALF);
      e.clkr = v && !(m_cnt < HALF);
      e.tag_stb = !v ? "R5" : (restart ? "R6" : "R2");
      e.tag_f   = !v ? "R5" : "R3";
      e.tag_r   = !v ? "R5" : "R4";
      q.push_back(e);
   endtask

   task automatic run(input bit v, input int n);
      for (int i = 0; i < n; i++) drive(v);
   endtask

   // Monitor: compares each registered result against the queue.
   always @(posedge clk) begin
      exp_t e;
      #2;
      if (rst_n && q.size() > 0) begin
         e = q.pop_front();
         check(e.tag_stb, "strobe(fall inst)", stb_f, e.stb);
         check(e.tag_stb, "strobe(rise inst)", stb_r, e.stb);
         check(e.tag_f, "mic_clk fall-drive", mclk_f, e.clkf);
         check(e.tag_r, "mic_clk rise-drive", mclk_r, e.clkr);
         check("R7", "edge_sel fall-drive", esel_f, 1'b0);
         check("R7", "edge_sel rise-drive", esel_r, 1'b1);
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      en = 1'b1;  // enable held high during reset must not leak out (R1)
      repeat (3) @(posedge clk);
      #2;
      check("R1", "reset mic_clk fall", mclk_f, 1'b0);
      check("R1", "reset mic_clk rise", mclk_r, 1'b0);
      check("R1", "reset strobe", stb_f | stb_r, 1'b0);
      check("R1", "reset edge_sel fall", esel_f, 1'b0);
      check("R1", "reset edge_sel rise", esel_r, 1'b1);
      @(negedge clk);
      en = 1'b0;
      rst_n = 1'b1;
      #1;
      check("R1", "post-reset mic_clk", mclk_f | mclk_r, 1'b0);
      check("R1", "post-reset strobe", stb_f | stb_r, 1'b0);
      run(0, 2);
      run(1, 30);   // several full periods and wraps (R2, R3, R4)
      run(0, 5);    // stop mid-period (R5)
      run(1, 3);    // restart from zero (R6)
      run(0, 2);
      run(1, 1);    // single-cycle run
      run(0, 3);
      run(1, HALF); // stop exactly at half period
      run(0, 1);
      run(1, 2 * DIV + 1);
      run(0, 4);
      repeat (3) @(posedge clk);
      #3;
      if (q.size() != 0) begin
         total++;
         bad++;
         $display("FAIL R2 queue drain: actual=%0d expected=0", q.size());
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule